// File: doc/BRIEF.md
# String Memory Operation Engine

This block runs block string instructions against a simple memory port. The caller loads three working registers when it starts an operation: a first pointer (destination, or first operand), a second value (source pointer, fill value or search key) and an element count. The engine then steps element by element through memory. It updates the three registers in place as it goes. On the operations that define them it also produces a zero flag and a carry flag.

Seven operations share one sequencer: byte compare until a mismatch or a null byte, fill-store, forward copy, backward copy, copy until a null byte, search until an element equals the key, and search while elements equal the key. The memory port takes byte, halfword or word accesses and returns read data one cycle after the request. A start/busy/done handshake frames each operation.

Top module: `strop_engine`

## Requirements
- R1: When the engine is idle, `start` loads `op_in`, `size_in` and the three register inputs. `busy` is high from the next cycle until the cycle after `done`. `done` is high for exactly one cycle, and the registers hold their final values from that cycle on. A `start` seen while `busy` is high is ignored.
- R2: For any operation whose count input is zero, the engine makes no memory access and raises `done` one cycle after `start`. The registers keep the loaded values and both flags keep their previous values.
- R3: For fill and both searches, a size code of 3 ends the operation at once with no memory access. Op code 7 is reserved and ends at once the same way.
- R4: Compare (op 0) reads the byte at R1 and then the byte at R2. It increments both pointers and decrements R3, and stops on a mismatch, on a zero byte, or when R3 reaches 0. Z is set when the last two bytes are equal. C is set when the R1 byte is greater than or equal to the R2 byte (unsigned).
- R5: Fill (op 1) writes the low 1, 2 or 4 bytes of R2 (size 0, 1, 2) to R1, steps R1 by 1 << size and decrements R3, until R3 reaches 0. The flags are unchanged.
- R6: Forward copy (op 2) and backward copy (op 3) move one byte from R2 to R1 and decrement R3 until it reaches 0. Forward increments both pointers and backward decrements them. The flags are unchanged.
- R7: Copy-until-null (op 4) copies forward as in R6 but also ends right after a zero byte has been written, with pointers and count already updated for that byte.
- R8: Search-until (op 5) reads zero-extended elements of 1 << size bytes at R1. It steps R1 and decrements R3 for each element, and stops when the element equals R2 or R3 reaches 0. Z is set when the last element equals R2. C is set when it is less than or equal to R2.
- R9: Search-while (op 6) steps as in R8 but stops when an element differs from R2 or R3 reaches 0. Z is set when the remaining R3 is zero. C is set when the last element is less than or equal to R2.
- R10: An element takes 1 cycle for fill, 2 cycles for copy and search, and 3 cycles for compare. `done` rises in the cycle after the last element, and R3 never increases while busy.
- R11: Memory is little-endian. `mem_size` 0, 1 or 2 selects 1, 2 or 4 bytes, and read data returns zero-extended in the low bits of `mem_rdata` the cycle after the request. Compare and copy access bytes only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_in | input | 3 | Operation code |
| size_in | input | 2 | Element size code for fill and search |
| r1_in | input | 32 | Initial first pointer |
| r2_in | input | 32 | Initial source pointer or value |
| r3_in | input | 32 | Initial count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| r1_out | output | 32 | Working first pointer |
| r2_out | output | 32 | Working source pointer or value |
| r3_out | output | 32 | Working count |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_size | output | 2 | Access size code |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data, low bytes significant |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
Compare is driven with equal null-terminated strings, a differing string and a run cut short by the count. These separate the three stop causes and the Z/C results each one leaves. Copy runs forward, backward and until null, both with a null inside the count and with the count running out first, so the pointer direction and the point of the null stop are exposed. The searches use byte, halfword and word elements with keys that are found early, never found, or break a run of equal elements; this distinguishes the stop rule from the count limit and checks the Z rule of search-while. Zero counts, size code 3 and the reserved op check that nothing is accessed and the flags survive. A second start mid-operation checks that it is ignored.

// File: rtl/strop_pkg.sv
package strop_pkg;
    parameter int unsigned XLEN = 32;

    typedef enum logic [2:0] {
        OP_CMP  = 3'd0,
        OP_FILL = 3'd1,
        OP_CPYF = 3'd2,
        OP_CPYB = 3'd3,
        OP_CPYZ = 3'd4,
        OP_SUNT = 3'd5,
        OP_SWHL = 3'd6,
        OP_NONE = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ACC0 = 3'd1,
        S_ACC1 = 3'd2,
        S_ACC2 = 3'd3,
        S_FIN  = 3'd4
    } st_e;

    typedef struct packed {
        st_e            st;
        op_e            op;
        logic [1:0]     sz;
        logic [XLEN-1:0] r1;
        logic [XLEN-1:0] r2;
        logic [XLEN-1:0] r3;
        logic [7:0]     hold;
        logic           z;
        logic           c;
    } eng_t;

    function automatic logic uses_size(op_e op);
        return (op == OP_FILL) || (op == OP_SUNT) || (op == OP_SWHL);
    endfunction

    function automatic logic is_copy(op_e op);
        return (op == OP_CPYF) || (op == OP_CPYB) || (op == OP_CPYZ);
    endfunction
endpackage

// File: rtl/strop_elem.sv
module strop_elem
    import strop_pkg::*;
(
    input  logic [1:0]      sz,
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] elem,
    output logic [XLEN-1:0] step
);
    localparam int unsigned NB = XLEN / 8;

    logic [NB-1:0] keep;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_lane
            assign elem[8*g +: 8] = keep[g] ? raw[8*g +: 8] : 8'h00;
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            keep[i] = (i < (1 << sz));
        end
        step = XLEN'(1) << sz;
    end
endmodule

// File: rtl/strop_judge.sv
module strop_judge
    import strop_pkg::*;
(
    input  op_e             op,
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  logic [XLEN-1:0] cnt_next,
    output logic            stop,
    output logic            z,
    output logic            c
);
    logic eq;

    always_comb begin
        eq   = (lhs == rhs);
        stop = 1'b0;
        z    = eq;
        c    = (lhs <= rhs);
        unique case (op)
            OP_CMP: begin
                c    = (lhs >= rhs);
                stop = !eq || (lhs == '0);
            end
            OP_SUNT: stop = eq;
            OP_SWHL: begin
                z    = (cnt_next == '0);
                stop = !eq;
            end
            OP_CPYZ: stop = (lhs == '0);
            default: stop = 1'b0;
        endcase
    end
endmodule

// File: rtl/strop_engine.sv
module strop_engine
    import strop_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op_in,
    input  logic [1:0]      size_in,
    input  logic [XLEN-1:0] r1_in,
    input  logic [XLEN-1:0] r2_in,
    input  logic [XLEN-1:0] r3_in,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] r1_out,
    output logic [XLEN-1:0] r2_out,
    output logic [XLEN-1:0] r3_out,
    output logic            flag_z,
    output logic            flag_c,
    output logic            mem_req,
    output logic            mem_we,
    output logic [1:0]      mem_size,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata
);
    eng_t q, d;

    logic [1:0]      eff_sz;
    logic [XLEN-1:0] elem, step, lhs, rhs, cnt_dec;
    logic            last, hit, jz, jc;
    op_e             op_new;

    assign eff_sz  = uses_size(q.op) ? q.sz : 2'd0;
    assign cnt_dec = q.r3 - XLEN'(1);
    assign last    = (cnt_dec == '0);
    assign lhs     = (q.op == OP_CMP) ? {{(XLEN-8){1'b0}}, q.hold} : elem;
    assign rhs     = (q.op == OP_CMP) ? {{(XLEN-8){1'b0}}, mem_rdata[7:0]} : q.r2;
    assign op_new  = op_e'(op_in);

    strop_elem u_elem (
        .sz   (eff_sz),
        .raw  (mem_rdata),
        .elem (elem),
        .step (step)
    );

    strop_judge u_judge (
        .op       (q.op),
        .lhs      (lhs),
        .rhs      (rhs),
        .cnt_next (cnt_dec),
        .stop     (hit),
        .z        (jz),
        .c        (jc)
    );

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_size  = eff_sz;
        mem_addr  = q.r1;
        mem_wdata = q.r2;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.op = op_new;
                    d.sz = size_in;
                    d.r1 = r1_in;
                    d.r2 = r2_in;
                    d.r3 = r3_in;
                    if (op_new == OP_NONE || r3_in == '0 ||
                        (uses_size(op_new) && size_in == 2'd3)) begin
                        d.st = S_FIN;
                    end else begin
                        d.st = S_ACC0;
                    end
                end
            end
            S_ACC0: begin
                mem_req = 1'b1;
                if (is_copy(q.op)) begin
                    mem_addr = q.r2;
                end
                if (q.op == OP_FILL) begin
                    mem_we = 1'b1;
                    d.r1   = q.r1 + step;
                    d.r3   = cnt_dec;
                    d.st   = last ? S_FIN : S_ACC0;
                end else begin
                    d.st = S_ACC1;
                end
            end
            S_ACC1: begin
                if (q.op == OP_CMP) begin
                    mem_req  = 1'b1;
                    mem_addr = q.r2;
                    d.hold   = mem_rdata[7:0];
                    d.st     = S_ACC2;
                end else if (is_copy(q.op)) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = elem;
                    if (q.op == OP_CPYB) begin
                        d.r1 = q.r1 - XLEN'(1);
                        d.r2 = q.r2 - XLEN'(1);
                    end else begin
                        d.r1 = q.r1 + XLEN'(1);
                        d.r2 = q.r2 + XLEN'(1);
                    end
                    d.r3 = cnt_dec;
                    d.st = (last || hit) ? S_FIN : S_ACC0;
                end else begin
                    d.r1 = q.r1 + step;
                    d.r3 = cnt_dec;
                    d.z  = jz;
                    d.c  = jc;
                    d.st = (last || hit) ? S_FIN : S_ACC0;
                end
            end
            S_ACC2: begin
                d.r1 = q.r1 + XLEN'(1);
                d.r2 = q.r2 + XLEN'(1);
                d.r3 = cnt_dec;
                d.z  = jz;
                d.c  = jc;
                d.st = (last || hit) ? S_FIN : S_ACC0;
            end
            S_FIN:   d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy   = (q.st != S_IDLE);
    assign done   = (q.st == S_FIN);
    assign r1_out = q.r1;
    assign r2_out = q.r2;
    assign r3_out = q.r3;
    assign flag_z = q.z;
    assign flag_c = q.c;
endmodule

// File: rtl/strop_engine_chk.sv
module strop_engine_chk
    import strop_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            mem_req,
    input logic [1:0]      mem_size,
    input logic [XLEN-1:0] r1_out,
    input logic [XLEN-1:0] r3_out
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1

    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(r1_out) && $stable(r3_out))); // R1

    AST_REQ_ONLY_WORKING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && !done)); // R2

    AST_LEGAL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_size != 2'd3)); // R3

    AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (r3_out <= $past(r3_out))); // R10
endmodule

bind strop_engine strop_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_size (mem_size),
    .r1_out   (r1_out),
    .r3_out   (r3_out)
);

// File: tb/strop_engine_bench.sv
module strop_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_in = '0;
    logic [1:0]  size_in = '0;
    logic [31:0] r1_in = '0, r2_in = '0, r3_in = '0;
    logic        busy, done, flag_z, flag_c, mem_req, mem_we;
    logic [31:0] r1_out, r2_out, r3_out, mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [31:0] mem_rdata = '0;

    logic [7:0] mem [0:255];
    logic [7:0] ref_mem [0:255];
    int acc_cnt = 0;
    int n_chk = 0, n_fail = 0;
    logic ez = 1'b0, ec = 1'b0;

    always #5 clk = ~clk;

    strop_engine u_strop_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in), .size_in(size_in),
        .r1_in(r1_in), .r2_in(r2_in), .r3_in(r3_in), .busy(busy), .done(done),
        .r1_out(r1_out), .r2_out(r2_out), .r3_out(r3_out), .flag_z(flag_z),
        .flag_c(flag_c), .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_we) begin
                for (int k = 0; k < (1 << mem_size); k++)
                    mem[(mem_addr + k) & 255] <= mem_wdata[8*k +: 8];
            end else begin
                logic [31:0] t;
                t = '0;
                for (int k = 0; k < (1 << mem_size); k++)
                    t[8*k +: 8] = mem[(mem_addr + k) & 255];
                mem_rdata <= t;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [7:0] v);
        mem[a & 255] = v;
        ref_mem[a & 255] = v;
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a, input int sz);
        logic [31:0] t = '0;
        for (int k = 0; k < (1 << sz); k++) t[8*k +: 8] = ref_mem[(a + k) & 255];
        return t;
    endfunction

    // Behavioural reference: whole operation, expected cycles and accesses.
    task automatic run(input int op, input int sz, input logic [31:0] a1,
                       input logic [31:0] a2, input logic [31:0] a3,
                       input string req, input bit poke);
        logic [31:0] x1 = a1, x2 = a2, x3 = a3, e, k;
        int n = 0, cpe = 0, ape = 0, cyc, acc0;
        bit go = 1, bad_busy = 0;
        logic [7:0] a = 0, b = 0;
        if (op == 0 && x3 != 0) begin
            cpe = 3; ape = 2;
            while (go) begin
                a = ref_mem[x1 & 255]; b = ref_mem[x2 & 255];
                x1++; x2++; x3--; n++;
                if (a != b || a == 0 || x3 == 0) go = 0;
            end
            ez = (a == b); ec = (a >= b);
        end else if (op == 1 && sz != 3) begin
            cpe = 1; ape = 1;
            while (x3 != 0) begin
                for (int i = 0; i < (1 << sz); i++) ref_mem[(x1 + i) & 255] = x2[8*i +: 8];
                x1 += (1 << sz); x3--; n++;
            end
        end else if (op >= 2 && op <= 4) begin
            cpe = 2; ape = 2;
            while (x3 != 0 && go) begin
                a = ref_mem[x2 & 255]; ref_mem[x1 & 255] = a;
                if (op == 3) begin x1--; x2--; end else begin x1++; x2++; end
                x3--; n++;
                if (op == 4 && a == 0) go = 0;
            end
        end else if ((op == 5 || op == 6) && sz != 3 && x3 != 0) begin
            cpe = 2; ape = 1; k = x2;
            while (go) begin
                e = rd(x1, sz); x1 += (1 << sz); x3--; n++;
                if (x3 == 0 || (op == 5 && e == k) || (op == 6 && e != k)) go = 0;
            end
            ez = (op == 5) ? (e == k) : (x3 == 0); ec = (e <= k);
        end
        @(negedge clk);
        start = 1; op_in = op[2:0]; size_in = sz[1:0]; r1_in = a1; r2_in = a2; r3_in = a3;
        acc0 = acc_cnt;
        @(negedge clk);
        start = 0; cyc = 1;
        while (!done && cyc < 3000) begin
            if (!busy) bad_busy = 1;
            if (poke && cyc == 2) begin
                start = 1; op_in = 3'd1; r1_in = 32'h90; r3_in = 32'd5;
            end else start = 0;
            @(negedge clk); cyc++;
        end
        start = 0;
        chk(!bad_busy && busy, "R1", "busy held until done", bad_busy, 0);
        chk(cyc == n * cpe + 1, "R10", {req, " cycles to done"}, cyc, n * cpe + 1);
        chk(acc_cnt - acc0 == n * ape, req, "memory accesses", acc_cnt - acc0, n * ape);
        chk(r1_out == x1, req, "R1 register", r1_out, x1);
        chk(r2_out == x2, req, "R2 register", r2_out, x2);
        chk(r3_out == x3, req, "R3 register", r3_out, x3);
        chk(flag_z == ez, req, "Z flag", flag_z, ez);
        chk(flag_c == ec, req, "C flag", flag_c, ec);
        begin
            int diff = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) diff++;
            chk(diff == 0, {req, "/R11"}, "memory image mismatches", diff, 0);
        end
        @(negedge clk);
        chk(!busy && !done, "R1", "idle after done", {busy, done}, 0);
    endtask

    initial begin
        #(10 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) put(i, 8'((i * 37 + 11) | 1));
        put(16, "a"); put(17, "b"); put(18, "c"); put(19, 0);
        put(32, "a"); put(33, "b"); put(34, "c"); put(35, 0);
        put(48, "a"); put(49, "b"); put(50, "d"); put(51, 0);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R1", "reset outputs", {busy, done, mem_req}, 0);
        chk(r3_out == 0 && !flag_z && !flag_c, "R1", "reset registers", r3_out, 0);
        rst_n = 1;
        // R4 compare: null stop, mismatch, count exhausted, then R2 zero count
        run(0, 0, 32'h10, 32'h20, 10, "R4", 0);
        run(0, 0, 32'h30, 32'h20, 10, "R4", 0);
        run(0, 0, 32'h10, 32'h20, 2, "R4", 0);
        run(0, 0, 32'h20, 32'h30, 10, "R4", 0);
        run(0, 0, 32'h10, 32'h30, 0, "R2", 0);
        // R5 fill at three sizes, R3 invalid size
        run(1, 0, 32'h40, 32'hA5, 3, "R5", 0);
        run(1, 1, 32'h48, 32'h1234, 2, "R5", 0);
        run(1, 2, 32'h50, 32'hDEADBEEF, 2, "R5", 0);
        run(1, 3, 32'h58, 32'h77, 2, "R3", 0);
        // R6 copy forward and backward, R7 null-terminated copy
        run(2, 0, 32'h60, 32'h10, 5, "R6", 0);
        run(3, 0, 32'h73, 32'h13, 4, "R6", 0);
        run(4, 0, 32'h80, 32'h10, 10, "R7", 0);
        run(4, 0, 32'h88, 32'h30, 2, "R7", 0);
        // R8 search-until at each size, found and not found
        run(5, 0, 32'h10, 32'h63, 10, "R8", 0);
        run(5, 0, 32'h10, 32'h7E, 3, "R8", 0);
        run(5, 1, 32'h50, 32'hDEAD, 4, "R8", 0);
        run(5, 2, 32'h50, 32'hDEADBEEF, 3, "R8", 0);
        // R9 search-while: break and exhaust
        run(6, 0, 32'h40, 32'hA5, 5, "R9", 0);
        run(6, 0, 32'h40, 32'hA5, 3, "R9", 0);
        run(6, 1, 32'h48, 32'h1234, 2, "R9", 0);
        // R2 zero count on search, R3 size 3 on search and reserved op
        run(5, 0, 32'h10, 32'h61, 0, "R2", 0);
        run(6, 3, 32'h10, 32'h61, 4, "R3", 0);
        run(7, 0, 32'h10, 32'h20, 4, "R3", 0);
        // R1 start while busy is ignored
        run(2, 0, 32'hA0, 32'h40, 6, "R1", 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule